// File: doc/BRIEF.md
# Error Status and ECC Error Log Register

This block keeps a 16-bit error status word whose defined bits are sticky flags. Each flag is set by a one-cycle hardware event strobe and cleared when software writes a 1 to it. Software sees the word through a small register port at byte offset C8h. Reads are combinational. A write to that offset clears the flags whose bits are 1 in the write data.

Each time a flag goes from 0 to 1, the block sends a single-cycle pulse on each of three notification channels: system error, management interrupt and configuration interrupt. A channel pulses only if its own 16-bit enable mask has that flag's bit set.

A 32-bit log records where memory ECC errors happened. A single-bit error records the address, channel and device. A multi-bit error records the address and device. While the flag of the error that filled the log is set, the log is frozen. A multi-bit error has priority over a single-bit error.

Top module: `err_status_log`

## Requirements
- R1: After a synchronous reset the status word, all three notification outputs and the log word are zero.
- R2: Bits 15:10 and 8:7 of the status word always read as zero. Events and writes on those bit positions have no effect.
- R3: An event on a defined bit sets that flag whatever the enable masks hold. Writing 1 to a bit at offset C8h clears that flag, and writing 0 leaves it unchanged. A write to any other offset is ignored, and a read at any other offset returns zero.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag ends up set. If the flag was already set, no notification pulse follows.
- R5: When a flag goes from 0 to 1 at a clock edge, each channel whose enable mask has that bit set is high for exactly the following cycle. Channels whose mask bit is clear stay low.
- R6: An event on a flag that is already set produces no notification pulse.
- R7: A single-bit ECC event (bit 0) captures the log word {address[25:0], channel[0], device[2:0], 2'b00}. This happens only when bit 0 and bit 1 are both clear and no multi-bit event occurs in the same cycle. The log is visible on the read port after that edge.
- R8: While bit 0 is set, further single-bit events leave the log unchanged. After bit 0 is cleared, the next single-bit event captures again.
- R9: A multi-bit ECC event (bit 1) captures {address, 1'b0, device, 2'b00} whenever bit 1 is clear, even if the log is locked by bit 0.
- R10: While bit 1 is set the log never changes. When a single-bit and a multi-bit event arrive together, the multi-bit contents are captured and both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | One-cycle event strobes, one per status bit |
| ecc_addr_i | input | 26 | Address of the ECC failure |
| ecc_chan_i | input | 1 | Channel of the ECC failure |
| ecc_dev_i | input | 3 | Device of the ECC failure |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Write data, where 1 clears a flag |
| reg_rdata_o | output | 16 | Status word when the offset matches, else zero |
| serr_en_i | input | 16 | System-error channel enable mask |
| smi_en_i | input | 16 | Management-interrupt channel enable mask |
| sci_en_i | input | 16 | Configuration-interrupt channel enable mask |
| serr_msg_o | output | 1 | System-error notification pulse |
| smi_msg_o | output | 1 | Management-interrupt notification pulse |
| sci_msg_o | output | 1 | Configuration-interrupt notification pulse |
| log_rdata_o | output | 32 | ECC error log word |

## Verification
Two pairs of functions can act in the same cycle: a hardware set and a software clear on one flag, and a single-bit and a multi-bit capture into the log. The bench provokes both on purpose. It raises an event on a flag while writing 1 to that same flag, once with the flag already set and once with it clear. It also strobes both ECC events on the same edge. A behavioural model in the bench applies the stated priority: set beats clear, and multi-bit beats single-bit. Every cycle, the model's flags, pulses and log word are compared with the design's outputs.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int STAT_W = 16;
  localparam int NUM_CH = 3;

  // flag positions
  localparam int B_SBE    = 0;
  localparam int B_MBE    = 1;
  localparam int B_BADGTT = 2;
  localparam int B_BADGFX = 3;
  localparam int B_OUTAP  = 4;
  localparam int B_UNKSPC = 5;
  localparam int B_TABORT = 6;
  localparam int B_LOCKNM = 9;

  localparam logic [STAT_W-1:0] DEF_MASK =
    (STAT_W'(1) << B_SBE)    | (STAT_W'(1) << B_MBE)    |
    (STAT_W'(1) << B_BADGTT) | (STAT_W'(1) << B_BADGFX) |
    (STAT_W'(1) << B_OUTAP)  | (STAT_W'(1) << B_UNKSPC) |
    (STAT_W'(1) << B_TABORT) | (STAT_W'(1) << B_LOCKNM);

  typedef enum logic [1:0] {CH_SERR = 2'd0, CH_SMI = 2'd1, CH_SCI = 2'd2} chan_e;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;

  // set has priority over a same-cycle clear
  always_comb begin
    flags_d = ((flags_q & ~clr_i) | set_i) & MASK;
    rise_o  = flags_d & ~flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/err_notify.sv
module err_notify #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rise_i,
  input  logic [NCH*W-1:0] en_i,
  output logic [NCH-1:0]   pulse_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = |(rise_i & en_i[ch*W +: W]);
    always_ff @(posedge clk) begin
      if (rst) pulse_o[ch] <= 1'b0;
      else     pulse_o[ch] <= hit;
    end
  end
endmodule

// File: rtl/err_ecc_log.sv
module err_ecc_log #(
  parameter int ADDR_W = 26,
  parameter int CHAN_W = 1,
  parameter int DEV_W  = 3,
  parameter int LOG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic              s_lock_i,
  input  logic              m_lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [DEV_W-1:0]  dev_i,
  output logic [LOG_W-1:0]  log_o
);
  localparam int PAD_W = LOG_W - ADDR_W - CHAN_W - DEV_W;

  logic [LOG_W-1:0] log_q;
  logic             cap_m;
  logic             cap_s;

  always_comb begin
    cap_m = mbe_i && !m_lock_i;
    cap_s = sbe_i && !s_lock_i && !m_lock_i && !mbe_i;
  end

  always_ff @(posedge clk) begin
    if (rst)        log_q <= '0;
    else if (cap_m) log_q <= {addr_i, {CHAN_W{1'b0}}, dev_i, {PAD_W{1'b0}}};
    else if (cap_s) log_q <= {addr_i, chan_i, dev_i, {PAD_W{1'b0}}};
  end

  assign log_o = log_q;
endmodule

// File: rtl/err_status_log.sv
module err_status_log
  import err_stat_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int CHAN_W     = 1,
  parameter int DEV_W      = 3,
  parameter int LOG_W      = 32,
  parameter int RA_W       = 8,
  parameter logic [RA_W-1:0] REG_OFFSET = 8'hC8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       evt_i,
  input  logic [ADDR_W-1:0] ecc_addr_i,
  input  logic [CHAN_W-1:0] ecc_chan_i,
  input  logic [DEV_W-1:0]  ecc_dev_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [15:0]       serr_en_i,
  input  logic [15:0]       smi_en_i,
  input  logic [15:0]       sci_en_i,
  output logic              serr_msg_o,
  output logic              smi_msg_o,
  output logic              sci_msg_o,
  output logic [LOG_W-1:0]  log_rdata_o
);
  logic              hit;
  logic [STAT_W-1:0] clr;
  logic [STAT_W-1:0] flags_q;
  logic [STAT_W-1:0] rise;
  logic [NUM_CH-1:0] pulse;

  assign hit = (reg_addr_i == REG_OFFSET);
  assign clr = (reg_wr_i && hit) ? reg_wdata_i : '0;

  err_flag_bank #(.W(STAT_W), .MASK(DEF_MASK)) u_flags (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr),
    .flags_o(flags_q), .rise_o(rise)
  );

  err_notify #(.W(STAT_W), .NCH(NUM_CH)) u_notify (
    .clk(clk), .rst(rst), .rise_i(rise),
    .en_i({sci_en_i, smi_en_i, serr_en_i}), .pulse_o(pulse)
  );

  err_ecc_log #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .DEV_W(DEV_W), .LOG_W(LOG_W)) u_log (
    .clk(clk), .rst(rst),
    .sbe_i(evt_i[B_SBE]), .mbe_i(evt_i[B_MBE]),
    .s_lock_i(flags_q[B_SBE]), .m_lock_i(flags_q[B_MBE]),
    .addr_i(ecc_addr_i), .chan_i(ecc_chan_i), .dev_i(ecc_dev_i),
    .log_o(log_rdata_o)
  );

  assign reg_rdata_o = hit ? flags_q : '0;
  assign serr_msg_o  = pulse[CH_SERR];
  assign smi_msg_o   = pulse[CH_SMI];
  assign sci_msg_o   = pulse[CH_SCI];
endmodule

// File: rtl/err_status_log_chk.sv
module err_status_log_chk
  import err_stat_pkg::*;
#(
  parameter int LOG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      evt_i,
  input logic [15:0]      flags_q,
  input logic [15:0]      serr_en_i,
  input logic             serr_msg_o,
  input logic [LOG_W-1:0] log_rdata_o
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~DEF_MASK) == '0);

  // R3
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags_q & $past(evt_i & DEF_MASK)) == $past(evt_i & DEF_MASK)));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && serr_msg_o) |->
      ((flags_q & ~$past(flags_q) & $past(serr_en_i)) != '0));

  // R6
  no_repulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ((flags_q & ~$past(flags_q) & $past(serr_en_i)) == '0)) |-> !serr_msg_o);

  // R10
  mlock_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flags_q[B_MBE])) |-> $stable(log_rdata_o));
endmodule

bind err_status_log err_status_log_chk #(.LOG_W(LOG_W)) chk_i (
  .clk(clk), .rst(rst), .evt_i(evt_i), .flags_q(flags_q),
  .serr_en_i(serr_en_i), .serr_msg_o(serr_msg_o), .log_rdata_o(log_rdata_o)
);

// File: tb/err_status_log_tb_top.sv
module err_status_log_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt = '0;
  logic [25:0] ecc_addr = '0;
  logic [0:0]  ecc_chan = '0;
  logic [2:0]  ecc_dev = '0;
  logic [7:0]  reg_addr = 8'hC8;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] serr_en = '0, smi_en = '0, sci_en = '0;
  logic        serr_msg, smi_msg, sci_msg;
  logic [31:0] log_rdata;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_flags = '0;
  logic        m_serr = 0, m_smi = 0, m_sci = 0;
  logic [31:0] m_log = '0;

  always #(CLK_P/2) clk = ~clk;

  err_status_log dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .ecc_addr_i(ecc_addr), .ecc_chan_i(ecc_chan),
    .ecc_dev_i(ecc_dev), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .serr_en_i(serr_en), .smi_en_i(smi_en), .sci_en_i(sci_en),
    .serr_msg_o(serr_msg), .smi_msg_o(smi_msg), .sci_msg_o(sci_msg), .log_rdata_o(log_rdata)
  );

  always @(posedge clk) begin
    logic [15:0] defined, nxt, up;
    defined = 16'h027F;
    if (rst) begin
      m_flags = '0; m_serr = 0; m_smi = 0; m_sci = 0; m_log = '0;
    end else begin
      if (evt[1] && !m_flags[1])
        m_log = {ecc_addr, 1'b0, ecc_dev, 2'b00};
      else if (evt[0] && !m_flags[0] && !m_flags[1])
        m_log = {ecc_addr, ecc_chan, ecc_dev, 2'b00};
      nxt = m_flags;
      if (reg_wr && reg_addr == 8'hC8) nxt = nxt & ~reg_wdata;
      nxt = (nxt | evt) & defined;
      up = nxt & ~m_flags;
      m_serr = |(up & serr_en);
      m_smi  = |(up & smi_en);
      m_sci  = |(up & sci_en);
      m_flags = nxt;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "status", {16'h0, reg_rdata}, {16'h0, (reg_addr == 8'hC8) ? m_flags : 16'h0});
    chk(cur_req, "serr", {31'h0, serr_msg}, {31'h0, m_serr});
    chk(cur_req, "smi",  {31'h0, smi_msg},  {31'h0, m_smi});
    chk(cur_req, "sci",  {31'h0, sci_msg},  {31'h0, m_sci});
    chk(cur_req, "log",  log_rdata, m_log);
  endtask

  // one clock: inputs already driven; after the edge compare, then idle the strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rst) compare_all();
    evt = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clr_all();
    reg_addr = 8'hC8; reg_wr = 1'b1; reg_wdata = 16'hFFFF; tick();
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "status", {16'h0, reg_rdata}, 32'h0);
    chk("R1", "msgs", {29'h0, serr_msg, smi_msg, sci_msg}, 32'h0);
    chk("R1", "log", log_rdata, 32'h0);

    // R3: set without enables, write 0, foreign offset, clear
    cur_req = "R3";
    evt = 16'h0010; tick();
    chk("R3", "flag4 set", {16'h0, reg_rdata}, 32'h0010);
    reg_wr = 1'b1; reg_wdata = 16'h0000; tick();
    chk("R3", "write0 keeps", {16'h0, reg_rdata}, 32'h0010);
    reg_addr = 8'hCA; reg_wr = 1'b1; reg_wdata = 16'hFFFF; tick();
    chk("R3", "other offset reads 0", {16'h0, reg_rdata}, 32'h0);
    reg_addr = 8'hC8; tick();
    chk("R3", "other offset write ignored", {16'h0, reg_rdata}, 32'h0010);
    reg_wr = 1'b1; reg_wdata = 16'h0010; tick();
    chk("R3", "w1c", {16'h0, reg_rdata}, 32'h0);

    // R2 reserved bits
    cur_req = "R2";
    evt = 16'hFFFF; tick();
    chk("R2", "reserved zero", {16'h0, reg_rdata}, 32'h027F);
    clr_all();

    // R5 per-channel pulses
    cur_req = "R5";
    serr_en = 16'h0004; smi_en = 16'h0200; sci_en = 16'h0020;
    evt = 16'h0004; tick();
    chk("R5", "serr pulse", {29'h0, serr_msg, smi_msg, sci_msg}, 32'h4);
    tick();
    chk("R5", "serr one cycle", {31'h0, serr_msg}, 32'h0);
    evt = 16'h0200; tick();
    chk("R5", "smi pulse", {29'h0, serr_msg, smi_msg, sci_msg}, 32'h2);
    evt = 16'h0020; tick();
    chk("R5", "sci pulse", {29'h0, serr_msg, smi_msg, sci_msg}, 32'h1);
    evt = 16'h0008; tick();
    chk("R5", "masked off", {29'h0, serr_msg, smi_msg, sci_msg}, 32'h0);

    // R6 already set
    cur_req = "R6";
    evt = 16'h0004; tick();
    chk("R6", "no repulse", {31'h0, serr_msg}, 32'h0);

    // R4 set and clear together
    cur_req = "R4";
    evt = 16'h0004; reg_wr = 1'b1; reg_wdata = 16'h0004; tick();
    chk("R4", "set wins", {16'h0, reg_rdata & 16'h0004}, 32'h0004);
    chk("R4", "no pulse", {31'h0, serr_msg}, 32'h0);
    clr_all();
    evt = 16'h0004; reg_wr = 1'b1; reg_wdata = 16'h0004; tick();
    chk("R4", "rise with clear pulses", {31'h0, serr_msg}, 32'h1);
    clr_all();
    serr_en = '0; smi_en = '0; sci_en = '0;

    // R7 single capture
    cur_req = "R7";
    evt = 16'h0001; ecc_addr = 26'h123_4567; ecc_chan = 1'b1; ecc_dev = 3'd5; tick();
    chk("R7", "single log", log_rdata, {26'h123_4567, 1'b1, 3'd5, 2'b00});

    // R8 lock and unlock
    cur_req = "R8";
    evt = 16'h0001; ecc_addr = 26'h0AB_CDEF; ecc_chan = 1'b0; ecc_dev = 3'd2; tick();
    chk("R8", "locked", log_rdata, {26'h123_4567, 1'b1, 3'd5, 2'b00});
    reg_wr = 1'b1; reg_wdata = 16'h0001; tick();
    evt = 16'h0001; tick();
    chk("R8", "unlocked recapture", log_rdata, {26'h0AB_CDEF, 1'b0, 3'd2, 2'b00});

    // R9 multi overrides single lock
    cur_req = "R9";
    evt = 16'h0002; ecc_addr = 26'h3FF_0001; ecc_chan = 1'b1; ecc_dev = 3'd7; tick();
    chk("R9", "multi log", log_rdata, {26'h3FF_0001, 1'b0, 3'd7, 2'b00});

    // R10 multi lock and simultaneous events
    cur_req = "R10";
    reg_wr = 1'b1; reg_wdata = 16'h0001; tick();
    evt = 16'h0001; ecc_addr = 26'h000_0F0F; ecc_dev = 3'd1; tick();
    chk("R10", "single blocked by multi", log_rdata, {26'h3FF_0001, 1'b0, 3'd7, 2'b00});
    evt = 16'h0002; ecc_addr = 26'h111_1111; tick();
    chk("R10", "multi blocked by multi", log_rdata, {26'h3FF_0001, 1'b0, 3'd7, 2'b00});
    clr_all();
    evt = 16'h0003; ecc_addr = 26'h2AA_AAAA; ecc_chan = 1'b1; ecc_dev = 3'd3; tick();
    chk("R10", "simultaneous multi wins", log_rdata, {26'h2AA_AAAA, 1'b0, 3'd3, 2'b00});
    chk("R10", "both flags", {16'h0, reg_rdata & 16'h0003}, 32'h0003);

    // mixed traffic covering R3 R4 R5 R6 R7 R8 R9 R10 against the model
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      evt       = 16'($urandom) & 16'($urandom);
      reg_wr    = ($urandom % 3) == 0;
      reg_wdata = 16'($urandom);
      reg_addr  = (($urandom % 5) == 0) ? 8'hCA : 8'hC8;
      serr_en   = 16'($urandom);
      smi_en    = 16'($urandom);
      sci_en    = 16'($urandom);
      ecc_addr  = 26'($urandom);
      ecc_chan  = 1'($urandom);
      ecc_dev   = 3'($urandom);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule